// File: doc/BRIEF.md
# Fan Soft-Start and Standby Sequencer

This block sits between the speed-command logic of a single-phase fan driver and its output PWM stage. It picks the working duty from two commands (a speed request and a minimum-speed floor), tracks how long that duty stays close to zero, and decides when the fan drops into standby. In standby the applied duty is zero, and the lock-protection timer gets a one-cycle clear request.

A soft-start ramp caps the duty handed to the output stage. The ramp restarts from zero in three cases: the block enters standby, it leaves standby, or lock protection issues a restart. Soft start can be switched off, and the ramp then reads as full scale. Capacitor timing is modelled with counters that advance on a clock-enable tick.

Top module: `fan_softstart_seq`

## Requirements
- R1: After reset, standby_o and lock_clr_o are 0, and duty_o is 0 while ss_en_i is 1. The on-time accumulator, ramp and ramp divider all start at 0.
- R2: The target duty is the larger of speed_duty_i and min_duty_i.
- R3: Outside standby, duty_o equals the smaller of the effective ramp value and the target duty.
- R4: With soft start enabled, each RAMP_DIV accepted ticks raise the ramp by one. The ramp saturates at full scale, which is 2^DUTY_W-1.
- R5: When ss_en_i is 0, the effective ramp is full scale, so duty_o equals the target duty. The ramp register is also loaded with full scale.
- R6: On each tick, the on-time accumulator changes by a rate that depends on the target duty. It adds UP_STEP, saturating at 2^ACC_W-1, when the target is below LOW_DUTY. Otherwise it subtracts 1+(target>>DN_SHIFT), saturating at 0.
- R7: Standby is entered on the tick where the accumulator, counting up, reaches STBY_THRESH. While in standby, duty_o is 0 and the ramp holds at 0.
- R8: lock_clr_o is high for exactly the one cycle in which standby_o first reads 1.
- R9: In standby, a target at or above LOW_DUTY clears standby at the next edge, with no tick needed. This also clears the accumulator, and the ramp then climbs from 0.
- R10: A restart_i pulse returns the ramp and its divider to 0 at the next edge. It takes precedence over a coincident tick.
- R11: With tick_i low, the accumulator and the ramp keep their values, except for the exits and restarts covered by R9 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable tick for the accumulator and the ramp |
| speed_duty_i | input | DUTY_W | Speed-command duty |
| min_duty_i | input | DUTY_W | Minimum-speed duty |
| restart_i | input | 1 | Restart request from lock protection |
| ss_en_i | input | 1 | Soft-start enable |
| duty_o | output | DUTY_W | Limited duty for the output stage |
| standby_o | output | 1 | Standby flag |
| lock_clr_o | output | 1 | One-cycle lock-timer clear strobe |

## Verification
The embedded assertions check several properties on every cycle:
- duty_o never exceeds the target duty or the effective ramp.
- The ramp never rises by more than one step per cycle.
- A restart leaves the ramp at zero.
- Standby can only start after a low-duty tick, and the clear strobe lines up with that entry.
- The accumulator is zero after an exit and does not move without a tick.

Only the bench's scenarios can show the exact timing:
- the number of ticks to standby after a mix of up and down counting at different duties;
- the divider period of the ramp;
- the immediate restart when drive returns.

The bench compares all three outputs against a behavioural model on every cycle.

// File: rtl/fan_ss_pkg.sv
package fan_ss_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_STBY = 1'b1
  } ss_mode_e;
endpackage

// File: rtl/fan_ss_target.sv
module fan_ss_target #(
  parameter int DUTY_W = 8
) (
  input  logic [DUTY_W-1:0] speed_i,
  input  logic [DUTY_W-1:0] floor_i,
  output logic [DUTY_W-1:0] target_o
);
  always_comb target_o = (speed_i > floor_i) ? speed_i : floor_i;
endmodule

// File: rtl/fan_ss_ontime.sv
module fan_ss_ontime
  import fan_ss_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int ACC_W       = 8,
  parameter int LOW_DUTY    = 3,
  parameter int UP_STEP     = 4,
  parameter int DN_SHIFT    = 5,
  parameter int STBY_THRESH = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] target_i,
  output logic              standby_o,
  output logic              enter_o,
  output logic              lock_clr_o
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [SUM_W-1:0] ACC_MAX = SUM_W'((1 << ACC_W) - 1);

  ss_mode_e         mode_q, mode_d;
  logic [ACC_W-1:0] acc_q, acc_d, acc_step;
  logic [SUM_W-1:0] up_sum, dn_amt;
  logic             low_w, exit_w, lock_clr_q;

  always_comb begin
    low_w  = target_i < DUTY_W'(LOW_DUTY);
    up_sum = {1'b0, acc_q} + SUM_W'(UP_STEP);
    dn_amt = SUM_W'(target_i >> DN_SHIFT) + SUM_W'(1);
    if (low_w)
      acc_step = (up_sum > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : up_sum[ACC_W-1:0];
    else
      acc_step = (dn_amt > {1'b0, acc_q}) ? '0 : acc_q - dn_amt[ACC_W-1:0];
  end

  always_comb begin
    enter_o = (mode_q == MODE_RUN) && tick_i && low_w &&
              (acc_step >= ACC_W'(STBY_THRESH));
    exit_w  = (mode_q == MODE_STBY) && !low_w;
    mode_d  = mode_q;
    if (enter_o)     mode_d = MODE_STBY;
    else if (exit_w) mode_d = MODE_RUN;
    if (exit_w)      acc_d = '0;
    else if (tick_i) acc_d = acc_step;
    else             acc_d = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RUN;
      acc_q      <= '0;
      lock_clr_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      acc_q      <= acc_d;
      lock_clr_q <= enter_o;
    end
  end

  assign standby_o  = (mode_q == MODE_STBY);
  assign lock_clr_o = lock_clr_q;

  AST_STBY_AFTER_LOW_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> $past(tick_i) && ($past(target_i) < DUTY_W'(LOW_DUTY))); // R7
  AST_CLR_ONLY_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_clr_o |-> standby_o && !$past(standby_o)); // R8
  AST_EXIT_ZERO_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) |-> acc_q == '0); // R9
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !exit_w) |=> $stable(acc_q)); // R11
endmodule

// File: rtl/fan_ss_ramp.sv
module fan_ss_ramp #(
  parameter int DUTY_W   = 8,
  parameter int RAMP_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic              tick_i,
  output logic [DUTY_W-1:0] ramp_o
);
  localparam logic [DUTY_W-1:0] FULL = '1;
  localparam int DIV_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;

  logic [DUTY_W-1:0] ramp_q;
  logic              step_w, adv_w, rst_div_w;

  assign adv_w     = en_i && !clr_i && !hold_i && tick_i;
  assign rst_div_w = !en_i || clr_i;

  generate
    if (RAMP_DIV > 1) begin : g_div
      logic [DIV_W-1:0] div_q;
      assign step_w = adv_w && (div_q == DIV_W'(RAMP_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        div_q <= '0;
        else if (rst_div_w) div_q <= '0;
        else if (step_w)    div_q <= '0;
        else if (adv_w)     div_q <= div_q + DIV_W'(1);
      end
    end else begin : g_nodiv
      assign step_w = adv_w;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ramp_q <= '0;
    else if (!en_i)                   ramp_q <= FULL;
    else if (clr_i)                   ramp_q <= '0;
    else if (step_w && ramp_q != FULL) ramp_q <= ramp_q + DUTY_W'(1);
  end

  assign ramp_o = en_i ? ramp_q : FULL;

  AST_RAMP_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && $past(en_i)) |-> ({1'b0, ramp_q} <= {1'b0, $past(ramp_q)} + 1'b1)); // R4
  AST_RAMP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> ramp_q == '0); // R10
  AST_RAMP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && (hold_i || !tick_i)) |=> $stable(ramp_q)); // R11
endmodule

// File: rtl/fan_softstart_seq.sv
module fan_softstart_seq #(
  parameter int DUTY_W      = 8,
  parameter int ACC_W       = 8,
  parameter int LOW_DUTY    = 3,
  parameter int UP_STEP     = 4,
  parameter int DN_SHIFT    = 5,
  parameter int STBY_THRESH = 200,
  parameter int RAMP_DIV    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] speed_duty_i,
  input  logic [DUTY_W-1:0] min_duty_i,
  input  logic              restart_i,
  input  logic              ss_en_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              standby_o,
  output logic              lock_clr_o
);
  logic [DUTY_W-1:0] target_w, ramp_w;
  logic              enter_w;

  fan_ss_target #(.DUTY_W(DUTY_W)) u_target (
    .speed_i (speed_duty_i),
    .floor_i (min_duty_i),
    .target_o(target_w)
  );

  fan_ss_ontime #(
    .DUTY_W(DUTY_W), .ACC_W(ACC_W), .LOW_DUTY(LOW_DUTY),
    .UP_STEP(UP_STEP), .DN_SHIFT(DN_SHIFT), .STBY_THRESH(STBY_THRESH)
  ) u_ontime (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .target_i  (target_w),
    .standby_o (standby_o),
    .enter_o   (enter_w),
    .lock_clr_o(lock_clr_o)
  );

  fan_ss_ramp #(.DUTY_W(DUTY_W), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ss_en_i),
    .clr_i (restart_i || enter_w),
    .hold_i(standby_o),
    .tick_i(tick_i),
    .ramp_o(ramp_w)
  );

  always_comb begin
    if (standby_o)             duty_o = '0;
    else if (ramp_w < target_w) duty_o = ramp_w;
    else                       duty_o = target_w;
  end

  AST_DUTY_UNDER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o <= speed_duty_i) || (duty_o <= min_duty_i) || (duty_o == '0)); // R2
  AST_DUTY_UNDER_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_o <= ramp_w); // R3
endmodule

// File: tb/fan_softstart_seq_tb_top.sv
module fan_softstart_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FULL = 255, LOWD = 3, UPS = 4, DNS = 5, THR = 200, ACCMAX = 255, DIV = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, restart_i = 1'b0, ss_en_i = 1'b1;
  logic [7:0] speed_duty_i = '0, min_duty_i = '0, duty_o;
  logic       standby_o, lock_clr_o;

  int checks = 0, errors = 0;
  int m_acc = 0, m_ramp = 0, m_div = 0;
  bit m_stby = 0, m_lclr = 0, done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fan_softstart_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .speed_duty_i(speed_duty_i),
    .min_duty_i(min_duty_i), .restart_i(restart_i), .ss_en_i(ss_en_i),
    .duty_o(duty_o), .standby_o(standby_o), .lock_clr_o(lock_clr_o)
  );

  function automatic int tgt();
    return (speed_duty_i > min_duty_i) ? int'(speed_duty_i) : int'(min_duty_i);
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int er, ed;
    er = ss_en_i ? m_ramp : FULL;
    ed = m_stby ? 0 : ((er < tgt()) ? er : tgt());
    chk("duty_o", int'(duty_o), ed);
    chk("standby_o", int'(standby_o), int'(m_stby));
    chk("lock_clr_o", int'(lock_clr_o), int'(m_lclr));
  endtask

  task automatic model_step();
    int t, step;
    bit low, enter, ex;
    t = tgt();
    low = t < LOWD;
    if (low) step = (m_acc + UPS > ACCMAX) ? ACCMAX : m_acc + UPS;
    else begin
      step = m_acc - (1 + (t >> DNS));
      if (step < 0) step = 0;
    end
    enter = !m_stby && tick_i && low && step >= THR;
    ex = m_stby && !low;
    if (!ss_en_i) begin m_ramp = FULL; m_div = 0; end
    else if (restart_i || enter) begin m_ramp = 0; m_div = 0; end
    else if (!m_stby && tick_i) begin
      if (m_div == DIV - 1) begin
        m_div = 0;
        if (m_ramp < FULL) m_ramp++;
      end else m_div++;
    end
    if (ex) m_acc = 0; else if (tick_i) m_acc = step;
    m_lclr = enter;
    if (enter) m_stby = 1; else if (ex) m_stby = 0;
  endtask

  // Inputs set just after a negedge; compare 1 time unit later; model advances at posedge.
  task automatic cyc(int spd, int mn, bit tk, bit rs, bit en);
    speed_duty_i = 8'(spd); min_duty_i = 8'(mn); tick_i = tk; restart_i = rs; ss_en_i = en;
    #1 compare();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic run(int n, int spd, int mn, int tk_every, bit en);
    for (int i = 0; i < n; i++) cyc(spd, mn, (i % tk_every) == 0, 1'b0, en);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    speed_duty_i = 8'd100;
    #(CLK_PERIOD * 2 + 1);
    chk("reset duty_o", int'(duty_o), 0);
    chk("reset standby_o", int'(standby_o), 0);
    chk("reset lock_clr_o", int'(lock_clr_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R4 / R3: ramp every DIV ticks, capping target
    cur_req = "R4"; run(60, 200, 10, 1, 1'b1);
    cur_req = "R3"; run(40, 12, 5, 2, 1'b1);
    // R11: no ticks, values hold
    cur_req = "R11"; run(20, 200, 0, 1000000, 1'b1);
    // R10: restart with coincident tick
    cur_req = "R10"; cyc(200, 0, 1'b1, 1'b1, 1'b1); run(12, 200, 0, 1, 1'b1);
    // R2 / R5: soft start disabled, max of the commands
    cur_req = "R2"; cyc(120, 30, 1'b1, 1'b0, 1'b0); cyc(20, 90, 1'b0, 1'b0, 1'b0); cyc(7, 7, 1'b1, 1'b0, 1'b0);
    cur_req = "R5"; run(5, 250, 0, 1, 1'b0); cyc(250, 0, 1'b1, 1'b1, 1'b0);
    cur_req = "R5"; run(6, 250, 0, 1, 1'b1);
    // R6: mixed up/down counting at various duties
    cur_req = "R6"; run(30, 0, 2, 1, 1'b1); run(5, 255, 0, 1, 1'b1); run(4, 40, 0, 1, 1'b1);
    run(3, 3, 0, 1, 1'b1);
    // R7 / R8: enter standby and saturate
    cur_req = "R7"; run(40, 0, 0, 1, 1'b1);
    cur_req = "R8"; run(40, 1, 0, 2, 1'b1);
    // R9: drive returns with no tick, ramp restarts from 0
    cur_req = "R9"; cyc(150, 0, 1'b0, 1'b0, 1'b1); run(30, 150, 0, 1, 1'b1);
    // R7: second standby entry with sparse ticks, then R10 restart during standby
    cur_req = "R7"; run(140, 0, 1, 2, 1'b1);
    cur_req = "R10"; cyc(0, 0, 1'b1, 1'b1, 1'b1); cur_req = "R9"; run(12, 0, 60, 1, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule